// File: doc/BRIEF.md
# Continuous-Flow Scan Stimulus Expander and Masked Response Compactor

This block sits between a handful of tester scan channels and a larger set of short internal scan chains. On the stimulus side, a linear feedback shift register takes fresh bits from the input channels on every shift cycle. A fixed network of XOR taps, the phase shifter, spreads its state so that every internal chain gets one bit per cycle. Chains are therefore filled in the same cycles that compressed data arrives. Every bit handed to a chain is an XOR-linear function of the seed and of the channel bits injected so far. The bits a test needs are found off-line by solving linear equations, and that solving is not part of this block.

On the response side, the chain outputs are reduced to the output channels by XOR trees. Each output channel owns a fixed, contiguous group of chains. The reduction advances only on shift cycles, in lockstep with the stimulus side. Before reduction, a per-chain mask forces to 0 any chain whose output is unknown. The mask is loaded serially into a staging register and takes effect only once all of its bits have arrived.

A small controller sequences the work through three states. `ST_IDLE` is the state after reset, before the first seed. `ST_RUN` is the seeded state, in which shifting is accepted. `ST_MASK` is a mask load in progress.

The transitions are as follows:
- `idle_to_run`: a seed request in `ST_IDLE`.
- `run_reseed`: a seed request in `ST_RUN`.
- `run_to_mask`: a mask bit in `ST_RUN` with no seed request.
- `mask_commit`: the last of NCHAIN mask bits arrives in `ST_MASK`; the state returns to `ST_RUN`.
- `mask_abort`: a seed request in `ST_MASK`; the state returns to `ST_RUN`.

Top module: `scan_comp_wrap`

## Requirements
- R1: After reset, the controller is in ST_IDLE. chan_out is all zeros, the active mask masks nothing, and the generator state equals SEED, so chain_si shows the phase-shifted SEED.
- R2: In ST_IDLE, shift_en and mask_load have no effect: chain_si and chan_out hold until seed_load is seen.
- R3: seed_load loads SEED into the generator at the next edge in any state. It wins over shift_en and mask_load on the same cycle, and the controller then sits in ST_RUN.
- R4: In ST_RUN, a cycle with shift_en (and no seed_load or mask_load) advances the state s to {s[W-2:0], ^(s & POLY)}. Each chan_in[c] is then XORed into bit c*(W/NCH) of that result.
- R5: chain_si[i] = s[i] ^ s[(i+5) mod W] ^ s[(i+11) mod W] at all times, where s is the current generator state.
- R6: On a shift cycle in ST_RUN, chan_out[k] becomes, at the next edge, the XOR of (chain_so[j] AND NOT mask[j]) for j from k*G to k*G+G-1, with G = NCHAIN/NCH. chan_out holds in every other cycle.
- R7: Each accepted mask_load cycle shifts mask_bit into staging position 0, and older bits move one position up. The NCHAIN-th bit replaces the active mask, so the first bit loaded lands on chain NCHAIN-1. A mask bit of 1 masks that chain.
- R8: While a mask load is incomplete (ST_MASK), the active mask is unchanged, and shift_en is ignored: chain_si and chan_out hold.
- R9: seed_load during ST_MASK abandons the partial load and leaves the active mask as it was. A later load again needs NCHAIN bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Restart the generator from SEED |
| shift_en | input | 1 | Shift cycle: advance generator and compactor |
| chan_in | input | NCH | Compressed stimulus from tester channels |
| chain_si | output | NCHAIN | One stimulus bit per internal chain |
| chain_so | input | NCHAIN | Unload bits from internal chains |
| mask_load | input | 1 | Serial mask bit valid |
| mask_bit | input | 1 | Serial mask data, 1 = mask chain |
| chan_out | output | NCH | Compacted response to tester channels |

## Verification
The bench aims at the following corner cases:
- Shift requests in `ST_IDLE` and during a partial mask load. A controller that let either through would move chain_si or chan_out.
- seed_load asserted together with shift_en and mask_load. Giving shift priority over the seed would leave a stepped state instead of SEED.
- A mask load cut short by a seed request. A design that committed the staging register early, or kept the count across the abort, would mask the wrong chains on the next unload.
- Mask bit order and polarity. These are checked by loading known patterns and then unloading all-ones chain data: a reversed shift or an inverted mask flips the group parities.

// File: rtl/tc_pkg.sv
package tc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_MASK = 2'd2
    } tc_state_e;

    typedef struct packed {
        logic seed;    // reload generator with the seed
        logic step;    // advance generator and compactor
        logic mshift;  // shift one mask bit into staging
        logic commit;  // staging becomes the active mask
    } tc_ctrl_t;

endpackage

// File: rtl/tc_ctrl_fsm.sv
module tc_ctrl_fsm
    import tc_pkg::*;
#(
    parameter int NCHAIN = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      seed_load,
    input  logic      shift_en,
    input  logic      mask_load,
    output tc_ctrl_t  ctrl,
    output tc_state_e state_o
);
    localparam int CW = $clog2(NCHAIN + 1);
    localparam logic [CW-1:0] LAST = CW'(NCHAIN - 1);

    tc_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // next-state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (seed_load) state_d = ST_RUN;            // idle_to_run
            end
            ST_RUN: begin
                if (seed_load) begin
                    state_d = ST_RUN;                       // run_reseed
                end else if (mask_load) begin
                    state_d = ST_MASK;                      // run_to_mask
                    cnt_d   = CW'(1);
                end
            end
            ST_MASK: begin
                if (seed_load) begin
                    state_d = ST_RUN;                       // mask_abort
                    cnt_d   = '0;
                end else if (mask_load) begin
                    if (cnt_q == LAST) begin
                        state_d = ST_RUN;                   // mask_commit
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            ST_IDLE: begin
                ctrl.seed = seed_load;
            end
            ST_RUN: begin
                ctrl.seed   = seed_load;
                ctrl.mshift = !seed_load && mask_load;
                ctrl.step   = !seed_load && !mask_load && shift_en;
            end
            ST_MASK: begin
                ctrl.seed   = seed_load;
                ctrl.mshift = !seed_load && mask_load;
                ctrl.commit = !seed_load && mask_load && (cnt_q == LAST);
            end
            default: ctrl = '0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/tc_lfsr_decomp.sv
module tc_lfsr_decomp #(
    parameter int          W      = 16,
    parameter int          NCH    = 3,
    parameter int          NCHAIN = 12,
    parameter logic [W-1:0] POLY  = 16'hB400,
    parameter logic [W-1:0] SEED  = 16'hACE1,
    parameter int          OFF1   = 5,
    parameter int          OFF2   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              step,
    input  logic [NCH-1:0]    chan_in,
    output logic [NCHAIN-1:0] chain_si,
    output logic [W-1:0]      state_o
);
    localparam int STRIDE = W / NCH;

    logic [W-1:0] s_q, s_next;

    always_comb begin
        s_next = {s_q[W-2:0], ^(s_q & POLY)};
        for (int c = 0; c < NCH; c++) begin
            s_next[c*STRIDE] = s_next[c*STRIDE] ^ chan_in[c];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    s_q <= SEED;
        else if (seed) s_q <= SEED;
        else if (step) s_q <= s_next;
    end

    // phase shifter: three fixed taps per chain
    for (genvar i = 0; i < NCHAIN; i++) begin : g_ps
        assign chain_si[i] = s_q[i % W] ^ s_q[(i + OFF1) % W] ^ s_q[(i + OFF2) % W];
    end

    assign state_o = s_q;

endmodule

// File: rtl/tc_xcompact.sv
module tc_xcompact #(
    parameter int NCH    = 3,
    parameter int NCHAIN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              mshift,
    input  logic              commit,
    input  logic              mask_bit,
    input  logic [NCHAIN-1:0] chain_so,
    output logic [NCH-1:0]    chan_out
);
    localparam int G = NCHAIN / NCH;

    logic [NCHAIN-1:0] stg_q, mask_q, stg_next, masked;
    logic [NCH-1:0]    comp, out_q;

    assign stg_next = {stg_q[NCHAIN-2:0], mask_bit};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q  <= '0;
            mask_q <= '0;
        end else begin
            if (mshift) stg_q  <= stg_next;
            if (commit) mask_q <= stg_next;
        end
    end

    assign masked = chain_so & ~mask_q;

    for (genvar k = 0; k < NCH; k++) begin : g_grp
        assign comp[k] = ^masked[k*G +: G];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    out_q <= '0;
        else if (step) out_q <= comp;
    end

    assign chan_out = out_q;

endmodule

// File: rtl/scan_comp_wrap.sv
module scan_comp_wrap
    import tc_pkg::*;
#(
    parameter int           NCH    = 3,
    parameter int           NCHAIN = 12,
    parameter int           LFSR_W = 16,
    parameter logic [15:0]  POLY   = 16'hB400,
    parameter logic [15:0]  SEED   = 16'hACE1,
    parameter int           OFF1   = 5,
    parameter int           OFF2   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic              shift_en,
    input  logic [NCH-1:0]    chan_in,
    output logic [NCHAIN-1:0] chain_si,
    input  logic [NCHAIN-1:0] chain_so,
    input  logic              mask_load,
    input  logic              mask_bit,
    output logic [NCH-1:0]    chan_out
);
    tc_ctrl_t          ctrl;
    tc_state_e         fsm_state;
    logic [LFSR_W-1:0] gen_state;

    tc_ctrl_fsm #(.NCHAIN(NCHAIN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_load (seed_load),
        .shift_en  (shift_en),
        .mask_load (mask_load),
        .ctrl      (ctrl),
        .state_o   (fsm_state)
    );

    tc_lfsr_decomp #(
        .W(LFSR_W), .NCH(NCH), .NCHAIN(NCHAIN),
        .POLY(POLY[LFSR_W-1:0]), .SEED(SEED[LFSR_W-1:0]),
        .OFF1(OFF1), .OFF2(OFF2)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed     (ctrl.seed),
        .step     (ctrl.step),
        .chan_in  (chan_in),
        .chain_si (chain_si),
        .state_o  (gen_state)
    );

    tc_xcompact #(.NCH(NCH), .NCHAIN(NCHAIN)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (ctrl.step),
        .mshift   (ctrl.mshift),
        .commit   (ctrl.commit),
        .mask_bit (mask_bit),
        .chain_so (chain_so),
        .chan_out (chan_out)
    );

endmodule

// File: rtl/scan_comp_wrap_chk.sv
module scan_comp_wrap_chk
    import tc_pkg::*;
#(
    parameter int          W      = 16,
    parameter int          NCH    = 3,
    parameter int          NCHAIN = 12,
    parameter logic [15:0] SEED   = 16'hACE1,
    parameter int          OFF1   = 5,
    parameter int          OFF2   = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seed_load,
    input logic              shift_en,
    input logic              mask_load,
    input logic [NCHAIN-1:0] chain_si,
    input logic [NCH-1:0]    chan_out,
    input tc_state_e         st,
    input logic [W-1:0]      gen_state
);
    function automatic logic [NCHAIN-1:0] seed_phase();
        logic [NCHAIN-1:0] r;
        logic [W-1:0]      s;
        s = SEED[W-1:0];
        for (int i = 0; i < NCHAIN; i++)
            r[i] = s[i % W] ^ s[(i + OFF1) % W] ^ s[(i + OFF2) % W];
        return r;
    endfunction

    // R3: a seed request always restarts from SEED and lands in ST_RUN
    a_r3_seed_restart: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (chain_si == seed_phase()) && (st == ST_RUN));

    // R2: nothing moves in idle without a seed
    a_r2_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !seed_load) |=> $stable(chain_si) && (chan_out == '0));

    // R8: shift requests ignored during a partial mask load
    a_r8_mask_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MASK && !seed_load) |=> $stable(gen_state) && $stable(chan_out));

    // R6: compactor output holds outside shift cycles
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chan_out));

    // R7: a mask load in ST_RUN moves the controller into ST_MASK
    a_r7_enter_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && mask_load && !seed_load) |=> (st == ST_MASK));

endmodule

bind scan_comp_wrap scan_comp_wrap_chk #(
    .W(LFSR_W), .NCH(NCH), .NCHAIN(NCHAIN), .SEED(SEED), .OFF1(OFF1), .OFF2(OFF2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .shift_en  (shift_en),
    .mask_load (mask_load),
    .chain_si  (chain_si),
    .chan_out  (chan_out),
    .st        (fsm_state),
    .gen_state (gen_state)
);

// File: tb/scan_comp_wrap_test.sv
`timescale 1ns/1ps
module scan_comp_wrap_test;
    localparam int NCH = 3, NCHAIN = 12, W = 16, G = NCHAIN / NCH;
    localparam logic [15:0] POLY = 16'hB400, SEED = 16'hACE1;

    logic clk = 0, rst_n = 0;
    logic seed_load = 0, shift_en = 0, mask_load = 0, mask_bit = 0;
    logic [NCH-1:0]    chan_in = '0;
    logic [NCHAIN-1:0] chain_so = '0;
    logic [NCHAIN-1:0] chain_si;
    logic [NCH-1:0]    chan_out;

    int checks = 0, failures = 0;
    bit done = 0;

    // model state
    logic [W-1:0]      m_s;
    logic [NCHAIN-1:0] m_stg, m_mask;
    logic [NCH-1:0]    m_out;
    int                m_st, m_cnt;   // 0 idle, 1 run, 2 mask

    always #2.5 clk = ~clk;

    scan_comp_wrap uut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .shift_en(shift_en),
        .chan_in(chan_in), .chain_si(chain_si), .chain_so(chain_so),
        .mask_load(mask_load), .mask_bit(mask_bit), .chan_out(chan_out)
    );

    function automatic logic [NCHAIN-1:0] ps(logic [W-1:0] s);
        logic [NCHAIN-1:0] r;
        for (int i = 0; i < NCHAIN; i++) r[i] = s[i % W] ^ s[(i+5) % W] ^ s[(i+11) % W];
        return r;
    endfunction

    function automatic logic [W-1:0] nstep(logic [W-1:0] s, logic [NCH-1:0] ci);
        logic [W-1:0] n;
        n = {s[W-2:0], ^(s & POLY)};
        for (int c = 0; c < NCH; c++) n[c*(W/NCH)] ^= ci[c];
        return n;
    endfunction

    function automatic logic [NCH-1:0] compact(logic [NCHAIN-1:0] so, logic [NCHAIN-1:0] mk);
        logic [NCH-1:0] r;
        for (int k = 0; k < NCH; k++) begin
            r[k] = 1'b0;
            for (int j = 0; j < G; j++) r[k] ^= so[k*G+j] & ~mk[k*G+j];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        case (m_st)
            0: if (seed_load) begin m_st = 1; m_s = SEED; end
            1: if (seed_load) m_s = SEED;
               else if (mask_load) begin m_stg = {m_stg[NCHAIN-2:0], mask_bit}; m_cnt = 1; m_st = 2; end
               else if (shift_en) begin m_out = compact(chain_so, m_mask); m_s = nstep(m_s, chan_in); end
            default: if (seed_load) begin m_st = 1; m_cnt = 0; m_s = SEED; end
               else if (mask_load) begin
                   m_stg = {m_stg[NCHAIN-2:0], mask_bit};
                   if (m_cnt == NCHAIN-1) begin m_mask = m_stg; m_st = 1; m_cnt = 0; end
                   else m_cnt++;
               end
        endcase
    endtask

    // one clock with current inputs; then check both outputs
    task automatic tick(string tag);
        @(posedge clk);
        model_update();
        #1;
        check({tag, " chain_si R5"}, 32'(chain_si), 32'(ps(m_s)));
        check({tag, " chan_out"},    32'(chan_out), 32'(m_out));
    endtask

    task automatic set_in(bit sd, bit sh, bit ml, bit mb);
        seed_load = sd; shift_en = sh; mask_load = ml; mask_bit = mb;
    endtask

    task automatic load_mask(logic [NCHAIN-1:0] pat, string tag);
        // first bit sent lands on chain NCHAIN-1 (R7)
        for (int i = NCHAIN-1; i >= 0; i--) begin
            set_in(0, 0, 1, pat[i]);
            tick(tag);
        end
        set_in(0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_c0de));
        m_s = SEED; m_stg = '0; m_mask = '0; m_out = '0; m_st = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1: reset values
        check("R1 chain_si", 32'(chain_si), 32'(ps(SEED)));
        check("R1 chan_out", 32'(chan_out), 0);

        // R2: shift and mask in idle are ignored
        chain_so = '1; chan_in = 3'b111;
        set_in(0, 1, 0, 0); tick("R2 shift_idle");
        set_in(0, 1, 1, 1); tick("R2 mask_idle");
        check("R2 chan_out_zero", 32'(chan_out), 0);

        // R3: seed wins over shift and mask
        set_in(1, 1, 1, 1); tick("R3 seed_prio");
        check("R3 seeded", 32'(chain_si), 32'(ps(SEED)));

        // R4/R6: a few directed shifts with no mask
        for (int i = 0; i < 6; i++) begin
            chan_in = 3'(i); chain_so = 12'hA5C ^ 12'(i * 77);
            set_in(0, 1, 0, 0); tick("R4 R6 shift");
        end
        set_in(0, 0, 0, 0); tick("R6 hold");

        // R7: load mask, then unload all ones
        load_mask(12'b1000_0110_0001, "R7 load");
        chain_so = '1; set_in(0, 1, 0, 0); tick("R7 masked_unload");
        // groups: chains 0-3 one masked ->3 ones ->1; 4-7 two masked ->0; 8-11 one masked ->1
        check("R7 parity", 32'(chan_out), 32'(3'b101));

        // R8/R9: partial load, shift ignored, then abort by seed
        set_in(0, 0, 1, 1); tick("R8 partial");
        set_in(0, 1, 0, 0); chain_so = 12'h3C3; tick("R8 shift_ignored");
        set_in(0, 0, 1, 0); tick("R8 partial2");
        set_in(1, 0, 1, 1); tick("R9 abort");
        chain_so = '1; set_in(0, 1, 0, 0); tick("R9 mask_kept");
        check("R9 parity", 32'(chan_out), 32'(3'b101));

        // R7: all masked then none masked
        load_mask('1, "R7 all");
        set_in(0, 1, 0, 0); chain_so = 12'hFFF; tick("R7 all_masked");
        check("R7 all_zero", 32'(chan_out), 0);
        load_mask('0, "R7 none");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            chan_in  = 3'($urandom);
            chain_so = 12'($urandom);
            set_in(r < 3, r >= 25, (r >= 3 && r < 25) || ($urandom_range(0, 9) == 0),
                   1'($urandom));
            tick("R4 R6 R7 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule